// File: doc/BRIEF.md
# MDIO Management Master with Single Command Register

This block lets software reach the management registers of an external Ethernet PHY through one 32-bit word. Software writes a command that carries a request flag, a read/write select, a 5-bit PHY address, a 5-bit register address and 16 data bits. The block then runs one clause-22 management frame on MDC/MDIO and clears the request flag when the frame is over. A read leaves the captured PHY data in the low half of the same word.

MDC is made from the system clock by a parameterized divider; `DIV_HALF` system cycles make one MDC half-period. The default of 20 gives 2.5 MHz from a 100 MHz clock. MDC stays low between frames. The MDIO output enable is dropped between frames, so the line idles high through the board pull-up. Software polls the request flag and issues a new command only after the flag has cleared.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset the command word reads 0, MDC is low, the MDIO output enable is low and the MDIO output is 1.
- R2: A write with bit 31 set while bit 31 reads 0 starts a frame. Bit 31 reads 1 from the next cycle until the frame ends. A frame is exactly 64 MDC periods, and bit 31 clears on the clock edge where the last MDC period falls.
- R3: Each frame starts with 32 ones and then the start pair 0,1, all driven.
- R4: The opcode pair is 1,0 when bit 30 is 1 (read) and 0,1 when bit 30 is 0 (write). After it come the PHY address from bits 25:21 and the register address from bits 20:16, each sent MSB first.
- R5: In a write frame the block drives the turnaround pair 1,0 and then bits 15:0, MSB first, so the output enable stays high for all 64 bits.
- R6: In a read frame the output enable is low for the last 18 bit periods (turnaround and data). The block samples MDIO on each of the last 16 MDC rising edges, MSB first. Once bit 31 clears, bits 15:0 hold that value and bits 30:16 read back as written.
- R7: While a frame runs, MDC is high and low for exactly `DIV_HALF` system cycles each.
- R8: The MDIO output changes only on a clock edge where MDC falls.
- R9: A write that arrives while bit 31 reads 1 is ignored. The running frame and the stored fields are unaffected.
- R10: Whenever bit 31 reads 0 the MDIO output enable is low.
- R11: A write with bit 31 clear, accepted while idle, stores bits 30:16 and 15:0 (bits 29:26 read 0) and starts no MDC activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Write strobe for the command word |
| cmd_wdata_i | input | 32 | Command word to write |
| cmd_rdata_o | output | 32 | Command word readback: request, read select, addresses, data |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO line as seen at the pad |

## Verification
The bench runs frames of both kinds over a spread of PHY and register addresses, including all-zero and all-one fields. For every MDC rising edge it records the enable and the line value and compares them bit by bit with a frame it builds arithmetically. If the opcode were swapped, an address sent LSB first, or the turnaround handled wrongly, the mismatch would show at a single bit position. A read whose sampling edge was off by one would return a shifted word. A model PHY answers reads with an address-dependent value, and frame length and busy time are counted in cycles, so an off-by-one in the divider or bit counter appears as a wrong total. Some frames receive a second command mid-flight: a design that accepted it would change the readback fields or corrupt the frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned FRAME_BITS = 64;
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);
  localparam int unsigned TA_POS     = 46;
  localparam int unsigned DATA_POS   = 48;

  typedef struct packed {
    logic        req;
    logic        rd;
    logic [3:0]  rsvd;
    logic [4:0]  phy;
    logic [4:0]  ra;
    logic [15:0] data;
  } cmd_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(input logic rd, input logic [4:0] phy,
                                                        input logic [4:0] ra, input logic [15:0] data);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra,
            (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : data)};
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int unsigned DIV_HALF = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = $clog2(DIV_HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          term;

  assign term   = run_i && (cnt_q == LAST);
  assign rise_o = term && !mdc_q;
  assign fall_o = term && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  is_rd_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  input  logic                  rise_i,
  input  logic                  fall_i,
  input  logic                  mdio_i,
  output logic                  mdio_o,
  output logic                  mdio_oe_o,
  output logic                  done_o,
  output logic [15:0]           rdata_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] sh_q;
  logic [IDX_W-1:0]      idx_q, idx_nx;
  logic                  oe_q, rd_q;
  logic [15:0]           cap_q;

  assign idx_nx    = idx_q + 1'b1;
  assign done_o    = fall_i && (idx_q == LAST_IDX);
  assign mdio_o    = sh_q[FRAME_BITS-1];
  assign mdio_oe_o = oe_q;
  assign rdata_o   = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '1;
      idx_q <= '0;
      oe_q  <= 1'b0;
      rd_q  <= 1'b0;
    end else if (start_i) begin
      sh_q  <= frame_i;
      idx_q <= '0;
      oe_q  <= 1'b1;
      rd_q  <= is_rd_i;
    end else if (fall_i) begin
      if (idx_q == LAST_IDX) begin
        sh_q <= '1;
        oe_q <= 1'b0;
      end else begin
        idx_q <= idx_nx;
        sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b1};
        oe_q  <= !(rd_q && (idx_nx >= IDX_W'(TA_POS)));
      end
    end
  end

  // sample on MDC rise through the data field of a read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_q <= '0;
    else if (rise_i && rd_q && (idx_q >= IDX_W'(DATA_POS))) cap_q <= {cap_q[14:0], mdio_i};
  end
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_pkg::*;
#(
  parameter int unsigned DIV_HALF = 20
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_we_i,
  input  logic [31:0] cmd_wdata_i,
  output logic [31:0] cmd_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  cmd_t        cmd_q, cmd_w;
  logic        accept, start, rise, fall, done;
  logic [15:0] cap;

  assign cmd_w  = cmd_t'(cmd_wdata_i);
  assign accept = cmd_we_i && !cmd_q.req;
  assign start  = accept && cmd_w.req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
    end else if (accept) begin
      cmd_q <= '{req: cmd_w.req, rd: cmd_w.rd, rsvd: 4'b0, phy: cmd_w.phy,
                 ra: cmd_w.ra, data: cmd_w.data};
    end else if (done) begin
      cmd_q.req <= 1'b0;
      if (cmd_q.rd) cmd_q.data <= cap;
    end
  end

  assign cmd_rdata_o = cmd_q;

  mdio_clk_div #(.DIV_HALF(DIV_HALF)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (cmd_q.req),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .is_rd_i   (cmd_w.rd),
    .frame_i   (build_frame(cmd_w.rd, cmd_w.phy, cmd_w.ra, cmd_w.data)),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .done_o    (done),
    .rdata_o   (cap)
  );
endmodule

// File: rtl/mdio_cmd_master_chk.sv
module mdio_cmd_master_chk #(
  parameter int unsigned DIV_HALF = 20
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_we_i,
  input logic [31:0] cmd_rdata_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o
);
  logic        mdc_d;
  int unsigned ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mdc_d <= 1'b0;
      ph_q  <= 0;
    end else begin
      mdc_d <= mdc_o;
      if (mdc_o != mdc_d)      ph_q <= 1;
      else if (!cmd_rdata_o[31]) ph_q <= 0;
      else                      ph_q <= ph_q + 1;
    end
  end

  // R7
  mdc_phase_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o != mdc_d) |-> (ph_q == DIV_HALF));

  // R8
  mdio_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdio_o) |-> $fell(mdc_o));

  // R10
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_rdata_o[31] |-> !mdio_oe_o);

  // R9
  busy_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_rdata_o[31] && cmd_we_i) |=> (cmd_rdata_o[30:16] == $past(cmd_rdata_o[30:16])));

  // R2
  end_on_last_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cmd_rdata_o[31]) |-> $fell(mdc_o));
endmodule

bind mdio_cmd_master mdio_cmd_master_chk #(.DIV_HALF(DIV_HALF)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_we_i    (cmd_we_i),
  .cmd_rdata_o (cmd_rdata_o),
  .mdc_o       (mdc_o),
  .mdio_o      (mdio_o),
  .mdio_oe_o   (mdio_oe_o)
);

// File: tb/mdio_cmd_master_test.sv
module mdio_cmd_master_test;
  localparam int HALF = 2;
  localparam int FRAME_CYC = 128 * HALF;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdo, moe, mdi;
  logic        phy_en = 1'b0, phy_bit = 1'b1;
  logic        cur_rd = 1'b0;
  logic [15:0] cur_resp = '0;
  logic        rec_oe [64];
  logic        rec_d  [64];
  int          nrise = 0;
  int          checks = 0, errors = 0;
  int          viol = 0;
  logic        mdo_prev = 1'b1, mdc_prev = 1'b0;

  always #5 clk = ~clk;

  assign mdi = moe ? mdo : (phy_en ? phy_bit : 1'b1);

  mdio_cmd_master #(.DIV_HALF(HALF)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(we), .cmd_wdata_i(wdata),
    .cmd_rdata_o(rdata), .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(moe), .mdio_i(mdi)
  );

  always @(posedge mdc) begin
    if (nrise < 64) begin
      rec_oe[nrise] = moe;
      rec_d[nrise]  = mdo;
    end
    nrise = nrise + 1;
  end

  always @(negedge mdc) begin
    if (cur_rd && nrise >= 48 && nrise < 64) begin
      phy_en  = 1'b1;
      phy_bit = cur_resp[63 - nrise];
    end else begin
      phy_en = 1'b0;
    end
  end

  // R8: line value may only move where MDC falls
  always @(negedge clk) begin
    if (rst_n && (mdo !== mdo_prev) && !(mdc_prev && !mdc)) viol = viol + 1;
    mdo_prev = mdo;
    mdc_prev = mdc;
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] p, input logic [4:0] r,
                                            input logic [15:0] d);
    logic [63:0] f;
    f[63:32] = 32'hFFFF_FFFF;
    f[31:30] = 2'b01;
    f[29:28] = rd ? 2'b10 : 2'b01;
    f[27:23] = p;
    f[22:18] = r;
    f[17:16] = 2'b10;
    f[15:0]  = d;
    return f;
  endfunction

  task automatic wr_cmd(input logic [31:0] w);
    @(negedge clk);
    we = 1'b1; wdata = w;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic run_frame(input logic rd, input logic [4:0] p, input logic [4:0] r, input logic inject);
    logic [15:0] d, resp;
    logic [63:0] f;
    logic [31:0] cmd;
    logic        ok;
    int          cyc;
    d    = {p, r, 6'h2B} ^ 16'hC35A;
    resp = {r, p, 6'h19} ^ 16'h9E61;
    cur_rd = rd; cur_resp = resp; nrise = 0;
    cmd = {1'b1, rd, 4'b0, p, r, d};
    wr_cmd(cmd);
    chk(rdata[31] === 1'b1, "R2 busy set", {32'b0, rdata}, 64'h8000_0000);
    cyc = 0;
    while (rdata[31] === 1'b1 && cyc < 4 * FRAME_CYC) begin
      cyc = cyc + 1;
      if (inject && cyc == 40) begin
        we = 1'b1; wdata = ~cmd;
      end else begin
        we = 1'b0;
      end
      @(negedge clk);
    end
    we = 1'b0;
    chk(cyc == FRAME_CYC, "R7 frame cycles", cyc, FRAME_CYC);
    chk(nrise == 64, "R2 mdc periods", nrise, 64);
    f = exp_frame(rd, p, r, rd ? resp : d);
    ok = 1'b1;
    for (int i = 0; i < 34; i++) if (rec_oe[i] !== 1'b1 || rec_d[i] !== f[63 - i]) ok = 1'b0;
    chk(ok, "R3 preamble/start", {p, r}, {p, r});
    ok = 1'b1;
    for (int i = 34; i < 46; i++) if (rec_oe[i] !== 1'b1 || rec_d[i] !== f[63 - i]) ok = 1'b0;
    chk(ok, "R4 opcode/addresses", {rd, p, r}, {rd, p, r});
    ok = 1'b1;
    for (int i = 46; i < 64; i++) begin
      if (rd) begin
        if (rec_oe[i] !== 1'b0) ok = 1'b0;
      end else if (rec_oe[i] !== 1'b1 || rec_d[i] !== f[63 - i]) ok = 1'b0;
    end
    if (rd) chk(ok, "R6 released turnaround/data", {p, r}, {p, r});
    else    chk(ok, "R5 write turnaround/data", d, d);
    if (rd) chk(rdata === {1'b0, 1'b1, 4'b0, p, r, resp}, "R6 read result", rdata, {1'b0, 1'b1, 4'b0, p, r, resp});
    else    chk(rdata === {2'b0, 4'b0, p, r, d}, "R5 write readback", rdata, {2'b0, 4'b0, p, r, d});
    if (inject) chk(rdata[30:16] === cmd[30:16], "R9 busy write ignored", rdata[30:16], cmd[30:16]);
    repeat (3) @(negedge clk);
    chk(moe === 1'b0 && mdo === 1'b1 && mdc === 1'b0, "R10 idle line", {moe, mdo, mdc}, 3'b010);
  endtask

  initial begin
    #2_000_000;
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0] phys [5];
    logic [4:0] regs [3];
    int         n;
    phys = '{5'd0, 5'd1, 5'd10, 5'd21, 5'd31};
    regs = '{5'd0, 5'd7, 5'd31};
    repeat (3) @(negedge clk);
    chk(rdata === 32'h0 && mdc === 1'b0 && moe === 1'b0 && mdo === 1'b1, "R1 reset state",
        {rdata, mdc, moe, mdo}, {32'h0, 3'b001});
    rst_n = 1'b1;
    @(negedge clk);
    // R11: stored without starting a frame
    wr_cmd(32'h7FFF_1234);
    repeat (20) @(negedge clk);
    chk(rdata === 32'h43FF_1234, "R11 store no start", rdata, 32'h43FF_1234);
    chk(nrise == 0 && mdc === 1'b0, "R11 no mdc", nrise, 0);
    n = 0;
    for (int op = 0; op < 2; op++)
      for (int a = 0; a < 5; a++)
        for (int b = 0; b < 3; b++) begin
          run_frame(op[0], phys[a], regs[b], (n % 4) == 1);
          n = n + 1;
        end
    chk(viol == 0, "R8 mdio moves only on mdc fall", viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule